// File: doc/BRIEF.md
# Second-Order Chirp Phase Oscillator

This block synthesises a linear frequency modulated chirp as complex baseband samples. Two adders form the phase. The first adds a constant step to a frequency word every sample. The second adds the updated frequency word to a phase word. Because the frequency word grows linearly, the instantaneous frequency sweeps linearly across the pulse. The upper phase bits address a quarter-shifted pair of reads from a sine table. The table is computed during elaboration. The reads give a cosine (I) and a sine (Q) sample.

Processor software converts centre frequency, bandwidth and pulse length into two 32-bit words. The start word is the frequency at the low edge of the band, which is the centre minus half the bandwidth. The step is the bandwidth divided by one less than the number of samples in the pulse. A one-cycle `pulse_start` strobe captures both words and rewinds both accumulators, so every pulse starts identically. The `tx_active` gate then marks the cycles that carry chirp samples. On gated-off cycles the outputs are zero and the accumulators hold their values.

The controller has two states. IDLE is entered from reset and emits nothing. SWEEP generates samples. The START transition goes from IDLE to SWEEP on `pulse_start`. The RESTART transition goes from SWEEP back to SWEEP on `pulse_start`. The only way back to IDLE is reset.

Top module: `chirp_nco`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `valid_out` is 0 and `i_out` and `q_out` are 0.
- R2: Before the first `pulse_start` after reset, `tx_active` has no effect: `valid_out` stays 0 and both outputs stay 0.
- R3: On a cycle with `pulse_start` high, the block captures `start_inc` and `inc_step`. Sample 0 of the new pulse then uses phase 0 with the captured start word as its frequency word.
- R4: For each later sample n, the frequency word is d[n] = d[n-1] + step.
- R5: For each later sample n, the phase is p[n] = p[n-1] + d[n]. In closed form, p[n] = n·start + step·n(n+1)/2.
- R6: For a sample with phase p, let a = p[31:22]. Then `i_out` = round(32767·cos(2πa/1024)) and `q_out` = round(32767·sin(2πa/1024)), both 16-bit two's complement, each within 1 LSB.
- R7: A sample is computed from the phase present during a cycle in SWEEP with `tx_active` high and `pulse_start` low. It appears on the outputs, with `valid_out` = 1, exactly one clock edge later.
- R8: A cycle with `tx_active` low produces `valid_out` = 0 and zero outputs one edge later. Both accumulators hold, so the next gated-on cycle continues with the next sample index.
- R9: `pulse_start` asserted during SWEEP restarts the chirp at sample 0 with the newly captured words. The strobe cycle itself produces no sample, even when `tx_active` is high.
- R10: Changes to `start_inc` or `inc_step` between strobes do not affect the samples of the running pulse.
- R11: Both accumulators wrap modulo 2^32, so a step or start word above 2^31 acts as a negative value in two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_start | input | 1 | One-cycle strobe: capture words and rewind the chirp |
| tx_active | input | 1 | Transmit gate; high cycles produce chirp samples |
| start_inc | input | 32 | Frequency word of sample 0 (low band edge) |
| inc_step | input | 32 | Per-sample frequency-word increment |
| i_out | output | 16 | In-phase (cosine) sample, signed |
| q_out | output | 16 | Quadrature (sine) sample, signed |
| valid_out | output | 1 | High when `i_out`/`q_out` carry a chirp sample |

## Verification
Every output follows the cycle that produced it by exactly one clock edge. This includes zero samples from gated-off cycles, from strobe cycles and from IDLE. The bench drives each cycle's inputs at the falling edge. It lets one rising edge pass and samples at the next falling edge, so every reading is paired with the inputs of the previous cycle. The bench keeps its own sample index, which advances only on gated-on non-strobe cycles. From that index it computes the expected phase with the closed-form sum. The expected I/Q values come from real-valued cosine and sine of the upper ten phase bits. One pulse uses a start word of 2^22 and a zero step, which walks through all 1024 table addresses once.

// File: rtl/chirp_nco_pkg.sv
package chirp_nco_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SWEEP = 1'b1
    } nco_state_e;

    // Sine of 2*pi*idx/depth scaled to the largest positive value of an
    // amp_w-bit signed word, rounded to nearest. Taylor series on [-pi, pi].
    function automatic int sine_entry(input int idx, input int depth, input int amp_w);
        real two_pi;
        real x;
        real term;
        real acc;
        real scaled;
        int  res;
        two_pi = 6.283185307179586;
        x      = two_pi * real'(idx) / real'(depth);
        if (x > 3.141592653589793) begin
            x = x - two_pi;
        end
        term = x;
        acc  = x;
        for (int k = 1; k <= 14; k++) begin
            term = -term * x * x / real'((2 * k) * (2 * k + 1));
            acc  = acc + term;
        end
        scaled = acc * real'((1 << (amp_w - 1)) - 1);
        if (scaled >= 0.0) begin
            res = $rtoi(scaled + 0.5);
        end else begin
            res = -$rtoi(-scaled + 0.5);
        end
        return res;
    endfunction

endpackage

// File: rtl/chirp_nco_ctrl.sv
module chirp_nco_ctrl
    import chirp_nco_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pulse_start,
    input  logic       tx_active,
    output logic       restart,
    output logic       advance,
    output nco_state_e state
);

    nco_state_e state_q;
    nco_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        restart = 1'b0;
        advance = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pulse_start) begin
                    state_d = ST_SWEEP;   // START
                    restart = 1'b1;
                end
            end
            ST_SWEEP: begin
                if (pulse_start) begin
                    state_d = ST_SWEEP;   // RESTART
                    restart = 1'b1;
                end else if (tx_active) begin
                    advance = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign state = state_q;

    AST_IDLE_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !advance);                                   // R2
    AST_STROBE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_start |-> (restart && !advance));                               // R9
    AST_SWEEP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWEEP) |=> (state_q == ST_SWEEP));                     // R9

endmodule

// File: rtl/chirp_nco_accum.sv
module chirp_nco_accum #(
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               advance,
    input  logic [PHASE_W-1:0] start_inc,
    input  logic [PHASE_W-1:0] inc_step,
    output logic [ADDR_W-1:0]  lut_addr
);

    localparam int TOP = PHASE_W - 1;

    logic [PHASE_W-1:0] inc_q;
    logic [PHASE_W-1:0] step_q;
    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] inc_nxt;
    logic [PHASE_W-1:0] phase_nxt;

    // Cascaded adders: frequency word first, then phase with the new word.
    assign inc_nxt   = inc_q + step_q;
    assign phase_nxt = phase_q + inc_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_q   <= '0;
            step_q  <= '0;
            phase_q <= '0;
        end else if (restart) begin
            inc_q   <= start_inc;
            step_q  <= inc_step;
            phase_q <= '0;
        end else if (advance) begin
            inc_q   <= inc_nxt;
            phase_q <= phase_nxt;
        end
    end

    assign lut_addr = phase_q[TOP -: ADDR_W];

    AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase_q == '0) && (inc_q == $past(start_inc)));         // R3
    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !restart) |=> ((inc_q - $past(inc_q)) == step_q));        // R4
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !restart) |=> ((phase_q - $past(phase_q)) == inc_q));     // R5
    AST_ACCUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !restart) |=> ($stable(phase_q) && $stable(inc_q)));     // R8
    AST_STEP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> $stable(step_q));                                        // R10

endmodule

// File: rtl/chirp_nco_lut.sv
module chirp_nco_lut
    import chirp_nco_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int AMP_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_en,
    input  logic [ADDR_W-1:0]       addr,
    output logic signed [AMP_W-1:0] cos_q,
    output logic signed [AMP_W-1:0] sin_q,
    output logic                    valid_q
);

    localparam int                DEPTH   = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] QUARTER = ADDR_W'(DEPTH / 4);

    logic signed [AMP_W-1:0] rom [DEPTH];
    logic [ADDR_W-1:0]       cos_addr;

    for (genvar g = 0; g < DEPTH; g++) begin : gen_rom
        localparam logic signed [AMP_W-1:0] ENTRY = AMP_W'(sine_entry(g, DEPTH, AMP_W));
        assign rom[g] = ENTRY;
    end

    // cos(x) = sin(x + quarter turn); wraps within ADDR_W bits.
    assign cos_addr = addr + QUARTER;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cos_q   <= '0;
            sin_q   <= '0;
            valid_q <= 1'b0;
        end else if (sample_en) begin
            cos_q   <= rom[cos_addr];
            sin_q   <= rom[addr];
            valid_q <= 1'b1;
        end else begin
            cos_q   <= '0;
            sin_q   <= '0;
            valid_q <= 1'b0;
        end
    end

    AST_LUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |=> valid_q);                                               // R7

endmodule

// File: rtl/chirp_nco.sv
module chirp_nco
    import chirp_nco_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 10,
    parameter int AMP_W   = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pulse_start,
    input  logic                    tx_active,
    input  logic [PHASE_W-1:0]      start_inc,
    input  logic [PHASE_W-1:0]      inc_step,
    output logic signed [AMP_W-1:0] i_out,
    output logic signed [AMP_W-1:0] q_out,
    output logic                    valid_out
);

    localparam longint AMP_MAX = (longint'(1) << (AMP_W - 1)) - 1;
    localparam longint MAG_LO  = (AMP_MAX - 2) * (AMP_MAX - 2);
    localparam longint MAG_HI  = (AMP_MAX + 2) * (AMP_MAX + 2);

    logic              restart;
    logic              advance;
    nco_state_e        state;
    logic [ADDR_W-1:0] lut_addr;

    chirp_nco_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .pulse_start (pulse_start),
        .tx_active   (tx_active),
        .restart     (restart),
        .advance     (advance),
        .state       (state)
    );

    chirp_nco_accum #(
        .PHASE_W (PHASE_W),
        .ADDR_W  (ADDR_W)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .advance   (advance),
        .start_inc (start_inc),
        .inc_step  (inc_step),
        .lut_addr  (lut_addr)
    );

    chirp_nco_lut #(
        .ADDR_W (ADDR_W),
        .AMP_W  (AMP_W)
    ) u_lut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (advance),
        .addr      (lut_addr),
        .cos_q     (i_out),
        .sin_q     (q_out),
        .valid_q   (valid_out)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> !valid_out);                                   // R2
    AST_GATE_LOW_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |=> (!valid_out && i_out == '0 && q_out == '0));           // R8
    AST_RESTART_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_start |=> !valid_out);                                          // R9
    AST_UNIT_MAGNITUDE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> ((longint'(i_out) * longint'(i_out) + longint'(q_out) * longint'(q_out)) >= MAG_LO
                    && (longint'(i_out) * longint'(i_out) + longint'(q_out) * longint'(q_out)) <= MAG_HI)); // R6

endmodule

// File: tb/chirp_nco_bench.sv
module chirp_nco_bench;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               pulse_start = 1'b0;
    logic               tx_active = 1'b0;
    logic [31:0]        start_inc = '0;
    logic [31:0]        inc_step = '0;
    logic signed [15:0] i_out;
    logic signed [15:0] q_out;
    logic               valid_out;

    int checks = 0;
    int failures = 0;

    // Bench model of the running pulse
    longint unsigned m_start = 0;
    longint unsigned m_step  = 0;
    int              idx     = 0;

    always #4 clk = ~clk;   // 125 MHz

    chirp_nco u_chirp_nco (
        .clk         (clk),
        .rst_n       (rst_n),
        .pulse_start (pulse_start),
        .tx_active   (tx_active),
        .start_inc   (start_inc),
        .inc_step    (inc_step),
        .i_out       (i_out),
        .q_out       (q_out),
        .valid_out   (valid_out)
    );

    function automatic int round_amp(input real v);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(-v + 0.5);
    endfunction

    // Drive one cycle's inputs, let one rising edge pass, sample at falling edge.
    task automatic cyc(input logic ps, input logic ga);
        pulse_start = ps;
        tx_active   = ga;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_zero(input string req);
        checks++;
        if (valid_out !== 1'b0 || i_out !== 16'sd0 || q_out !== 16'sd0) begin
            failures++;
            $display("FAIL %s: valid=%0d i=%0d q=%0d expected valid=0 i=0 q=0",
                     req, valid_out, i_out, q_out);
        end
    endtask

    task automatic check_sample(input string req, input int n);
        longint unsigned nn;
        longint unsigned ph;
        int              a;
        int              ei;
        int              eq;
        real             ang;
        nn  = longint'(n);
        ph  = (nn * m_start + m_step * ((nn * (nn + 1)) / 2)) & 64'hFFFF_FFFF;
        a   = int'(ph >> 22);
        ang = 6.283185307179586 * real'(a) / 1024.0;
        ei  = round_amp(32767.0 * $cos(ang));
        eq  = round_amp(32767.0 * $sin(ang));
        checks++;
        if (valid_out !== 1'b1 || (int'(i_out) - ei) > 1 || (ei - int'(i_out)) > 1
            || (int'(q_out) - eq) > 1 || (eq - int'(q_out)) > 1) begin
            failures++;
            $display("FAIL %s: n=%0d valid=%0d i=%0d q=%0d expected valid=1 i=%0d q=%0d",
                     req, n, valid_out, i_out, q_out, ei, eq);
        end
    endtask

    // Strobe with new words; the strobe cycle must yield no sample (R3, R9).
    task automatic strobe(input logic [31:0] s, input logic [31:0] d, input logic ga);
        start_inc = s;
        inc_step  = d;
        m_start   = longint'(s);
        m_step    = longint'(d);
        idx       = 0;
        cyc(1'b1, ga);
        check_zero("R9");
    endtask

    task automatic run(input string req, input int count);
        for (int k = 0; k < count; k++) begin
            cyc(1'b0, 1'b1);
            check_sample(req, idx);
            idx++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        repeat (4) begin
            cyc(1'b0, 1'b1);
            check_zero("R1");
        end
        rst_n = 1'b1;
        // R1 first cycle after release, gate low
        cyc(1'b0, 1'b0);
        check_zero("R1");

        // R2: gate with no strobe yet
        start_inc = 32'h0123_4567;
        inc_step  = 32'h0000_1000;
        for (int k = 0; k < 6; k++) begin
            cyc(1'b0, 1'b1);
            check_zero("R2");
        end

        // R3/R4/R5/R7: basic upward sweep
        strobe(32'h0100_0000, 32'h0008_0000, 1'b0);
        run("R5", 40);
        // R7: sample ends exactly one edge after the gate drops
        cyc(1'b0, 1'b0);
        check_zero("R7");

        // R8: pause, then continue with the next index
        for (int k = 0; k < 3; k++) begin
            cyc(1'b0, 1'b0);
            check_zero("R8");
        end
        run("R8", 10);

        // R10: change words mid-pulse, samples keep old words
        start_inc = 32'hDEAD_BEEF;
        inc_step  = 32'h1234_5678;
        run("R10", 12);

        // R9: restart during sweep with gate high
        strobe(32'h0400_0000, 32'h0010_0000, 1'b1);
        run("R9", 30);

        // R11/R4: negative step, wrapping start
        strobe(32'hF000_0000, 32'hFFF0_0000, 1'b0);
        run("R11", 60);
        cyc(1'b0, 1'b0);
        check_zero("R8");

        // R6: address walk over every table entry
        strobe(32'h0040_0000, 32'h0000_0000, 1'b0);
        run("R6", 1024);

        // R3: a second strobe gives the same first samples again
        strobe(32'h0100_0000, 32'h0008_0000, 1'b0);
        run("R3", 5);
        cyc(1'b0, 1'b0);
        check_zero("R8");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule